// File: doc/BRIEF.md
# Masked Bit-Pattern Manipulation Unit

This unit is a 64-bit execution stage for one generalised bit-pattern operation. It produces the common lowest-set-bit masks: isolate the lowest set bit, set the bits below it, set the bits up to and including it, clear the trailing ones, and their relatives. Every variant runs under a per-bit predicate mask. A 5-bit selector chooses the variant. A flag says whether the mask operand is in use or whether the mask is all ones. A keep flag says whether source bits outside the mask pass through to the result or are cleared.

The selector has three fields:
- Bit 0 picks the first term.
- Bits 2..1 pick the second term. The choices are a negate, decrement or increment of the masked source, or the complement of the increment.
- Bits 4..3 pick how the two terms are combined.

The unit computes the result and an illegal-operation flag and registers them together in one pipeline stage. The input and output each use a valid/ready handshake. An input transfers on a clock edge where `in_valid` and `in_ready` are both high. An output transfers on a clock edge where `out_valid` and `out_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. While the output is stalled, the held result and flag do not change. Decode, register access and trap handling lie outside the unit: it only reports the reserved combiner code on `out_illegal`.

Top module: `bm_unit`

## Requirements
- R1: The effective mask is all ones when `in_mask_zero` is 1, and equals `in_mask` when it is 0. The working value `ra` is `in_src` AND the effective mask, and every later step uses `ra`.
- R2: Selector bit 0 picks the first term: 1 gives `ra`, 0 gives `~ra`.
- R3: Selector bits 2..1, read as a number, pick the second term: 0 gives `~ra+1`, 1 gives `ra-1`, 2 gives `ra+1`, 3 gives `~(ra+1)`. Both terms are ANDed with the effective mask before they are combined.
- R4: Selector bits 4..3, read as a number, pick the combiner: 0 is OR, 1 is AND, 2 is XOR.
- R5: Combiner code 3 is reserved. It sets `out_illegal` to 1 and gives a result of all zeros, whatever the keep flag says. For every other code `out_illegal` is 0.
- R6: The combined value is ANDed with the effective mask. With `in_keep` at 0, every bit outside the mask is 0.
- R7: With `in_keep` at 1 and a non-reserved combiner, the result bits outside the mask equal the corresponding `in_src` bits.
- R8: The selector gives these named patterns on the masked value:
  - 0b01010 sets the bits below the lowest set bit.
  - 0b01001 isolates the lowest set bit.
  - 0b10000 and 0b10011 set the bits up to and including the lowest set bit.
- R9: All arithmetic is modulo 2^64. `ra-1` with `ra` at zero gives all ones, and `ra+1` with `ra` at all ones gives zero.
- R10: `out_valid` is 1 in the cycle after an accepted input.
- R11: While `out_valid` is 1 and `out_ready` is 0:
  - `out_result` and `out_illegal` hold their values.
  - `out_valid` stays 1.
  - `in_ready` is 0.
- R12: During and directly after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set is valid |
| in_ready | output | 1 | Unit can take an operand set this cycle |
| in_src | input | 64 | Source operand |
| in_mask | input | 64 | Mask operand |
| in_mask_zero | input | 1 | 1: ignore `in_mask` and use all ones |
| in_sel | input | 5 | Operation selector |
| in_keep | input | 1 | 1: pass source bits outside the mask through |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Result |
| out_illegal | output | 1 | The reserved combiner code was used |

## Verification
The bench sweeps all 32 selector values, both keep settings and both mask sources. It uses all-zero, all-ones, sparse and edge-bit operands, including an empty mask.

Each corner case targets a specific kind of defect:
- Wraparound cases with zero and all-ones working values catch a design that saturates or drops the carry.
- A zero mask with the zero flag set catches a design that uses the mask operand anyway.
- Reserved codes with keep set catch a design that ORs source bits into what should be an all-zero result.
- A stall lasting several cycles, followed by uneven ready patterns, catches a design that loses or overwrites a result held under back-pressure.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int SEL_W = 5;
  localparam int FIRST_BIT = 0;
  localparam int T2_LO = 1;
  localparam int CMB_LO = 3;

  typedef enum logic [1:0] {
    T2_NEG  = 2'd0,
    T2_DEC  = 2'd1,
    T2_INC  = 2'd2,
    T2_NINC = 2'd3
  } term2_e;

  typedef enum logic [1:0] {
    CMB_OR  = 2'd0,
    CMB_AND = 2'd1,
    CMB_XOR = 2'd2,
    CMB_RSV = 2'd3
  } comb_e;
endpackage

// File: rtl/bm_terms.sv
module bm_terms
  import bm_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] mask,
  input  logic         pick_true,
  input  term2_e       t2sel,
  output logic [W-1:0] t1,
  output logic [W-1:0] t2
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] base;
  logic [W-1:0] addend;
  logic [W-1:0] sum;

  // one shared adder: negate = ~v + 1, dec = v + all-ones, inc = v + 1
  always_comb begin
    base   = (t2sel == T2_NEG) ? ~val : val;
    addend = (t2sel == T2_DEC) ? ONES : ONE;
    sum    = base + addend;
    t1     = (pick_true ? val : ~val) & mask;
    t2     = ((t2sel == T2_NINC) ? ~sum : sum) & mask;
  end
endmodule

// File: rtl/bm_merge.sv
module bm_merge
  import bm_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] t1,
  input  logic [W-1:0] t2,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] src,
  input  logic         keep,
  input  comb_e        op,
  output logic [W-1:0] res,
  output logic         illegal
);
  logic [W-1:0] comb;

  always_comb begin
    illegal = 1'b0;
    unique case (op)
      CMB_OR:  comb = t1 | t2;
      CMB_AND: comb = t1 & t2;
      CMB_XOR: comb = t1 ^ t2;
      default: begin
        comb    = '0;
        illegal = 1'b1;
      end
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      if (illegal)      res[i] = 1'b0;
      else if (mask[i]) res[i] = comb[i];
      else              res[i] = keep & src[i];
    end
  end
endmodule

// File: rtl/bm_unit.sv
module bm_unit
  import bm_pkg::*;
#(
  parameter int W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_src,
  input  logic [W-1:0]     in_mask,
  input  logic             in_mask_zero,
  input  logic [SEL_W-1:0] in_sel,
  input  logic             in_keep,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_result,
  output logic             out_illegal
);
  logic [W-1:0] mask_eff;
  logic [W-1:0] ra;
  logic [W-1:0] t1;
  logic [W-1:0] t2;
  logic [W-1:0] res_d;
  logic         ill_d;
  logic         acc;

  assign mask_eff = in_mask_zero ? '1 : in_mask;
  assign ra       = in_src & mask_eff;
  assign in_ready = ~out_valid | out_ready;
  assign acc      = in_valid & in_ready;

  bm_terms #(.W(W)) u_terms (
    .val       (ra),
    .mask      (mask_eff),
    .pick_true (in_sel[FIRST_BIT]),
    .t2sel     (term2_e'(in_sel[T2_LO +: 2])),
    .t1        (t1),
    .t2        (t2)
  );

  bm_merge #(.W(W)) u_merge (
    .t1      (t1),
    .t2      (t2),
    .mask    (mask_eff),
    .src     (in_src),
    .keep    (in_keep),
    .op      (comb_e'(in_sel[CMB_LO +: 2])),
    .res     (res_d),
    .illegal (ill_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else begin
      if (acc) begin
        out_valid   <= 1'b1;
        out_result  <= res_d;
        out_illegal <= ill_d;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  a_r10_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r11_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_sel[CMB_LO +: 2] == 2'b11) |=> (out_illegal && out_result == '0));

  a_r6_outside_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_keep) |=> ((out_result & ~$past(mask_eff)) == '0));

  a_r7_outside_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_keep && in_sel[CMB_LO +: 2] != 2'b11) |=>
      ((out_result & ~$past(mask_eff)) == ($past(in_src) & ~$past(mask_eff))));

  a_r12_reset_empty: assert property (@(posedge clk)
    !rst_n |-> !out_valid);
endmodule

// File: tb/sim_bm_unit.sv
module sim_bm_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_src = '0;
  logic [W-1:0]  in_mask = '0;
  logic          in_mask_zero = 1'b0;
  logic [4:0]    in_sel = '0;
  logic          in_keep = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [W-1:0]  out_result;
  logic          out_illegal;

  int checks = 0;
  int failures = 0;
  bit hold = 1'b0;
  bit stall_en = 1'b0;
  int unsigned cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [W-1:0] res;
    logic         ill;
    string        tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bm_unit #(.W(W)) u0 (
    .clk, .rst_n, .in_valid, .in_ready, .in_src, .in_mask, .in_mask_zero,
    .in_sel, .in_keep, .out_valid, .out_ready, .out_result, .out_illegal
  );

  function automatic logic [W:0] model(logic [W-1:0] s, logic [W-1:0] m,
                                       logic mz, logic [4:0] sel, logic keep);
    logic [W-1:0] mk, ra, a1, a2, r;
    mk = mz ? {W{1'b1}} : m;
    ra = s & mk;
    a1 = sel[0] ? ra : ~ra;
    case (sel[2:1])
      2'd0: a2 = 64'd0 - ra;
      2'd1: a2 = ra - 64'd1;
      2'd2: a2 = ra + 64'd1;
      default: a2 = ~(ra + 64'd1);
    endcase
    a1 = a1 & mk;
    a2 = a2 & mk;
    case (sel[4:3])
      2'd0: r = a1 | a2;
      2'd1: r = a1 & a2;
      2'd2: r = a1 ^ a2;
      default: return {1'b1, {W{1'b0}}};
    endcase
    r = r & mk;
    if (keep) r = r | (s & ~mk);
    return {1'b0, r};
  endfunction

  task automatic check(bit ok, string tag, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ready pattern and output monitor
  always @(negedge clk) begin
    cyc++;
    out_ready = hold ? 1'b0 : (stall_en ? (cyc % 3 != 0) : 1'b1);
    #1;
    if (rst_n && out_valid && out_ready) begin
      exp_t e;
      if (q.size() == 0) begin
        check(1'b0, "R10 unexpected output", {out_illegal, out_result}, '0);
      end else begin
        e = q.pop_front();
        check({out_illegal, out_result} === {e.ill, e.res}, e.tag,
              {out_illegal, out_result}, {e.ill, e.res});
      end
    end
  end

  task automatic send(logic [W-1:0] s, logic [W-1:0] m, logic mz,
                      logic [4:0] sel, logic keep, logic [W:0] exp, string tag);
    exp_t e;
    @(negedge clk); #2;
    in_src = s; in_mask = m; in_mask_zero = mz; in_sel = sel; in_keep = keep;
    in_valid = 1'b1;
    while (!in_ready) begin @(negedge clk); #2; end
    e.res = exp[W-1:0]; e.ill = exp[W]; e.tag = tag;
    q.push_back(e);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic sendm(logic [W-1:0] s, logic [W-1:0] m, logic mz,
                       logic [4:0] sel, logic keep, string tag);
    send(s, m, mz, sel, keep, model(s, m, mz, sel, keep), tag);
  endtask

  task automatic drain();
    int n = 0;
    while (q.size() != 0 && n < 100) begin @(negedge clk); n++; end
    @(negedge clk); #2;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] X68 = 64'h68;

  initial begin
    logic [W-1:0] srcs [4];
    logic [W-1:0] masks[4];
    srcs  = '{64'h0, ONES, 64'h0000_0F00_00A0_0000, 64'h8000_0000_0000_0001};
    masks = '{ONES, 64'hFFFF_0000_FFFF_0000, 64'h00FF_FF00_0F0F_F0F0, 64'h0};

    // R12: reset state
    repeat (3) @(negedge clk);
    #2;
    check(!out_valid && in_ready, "R12 during reset", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check(!out_valid && in_ready, "R12 after reset", {out_valid, in_ready}, 2'b01);

    // R10: latency
    send(X68, ONES, 1'b0, 5'b01001, 1'b0, {1'b0, 64'h8}, "R10 data");
    check(out_valid === 1'b1, "R10 valid next cycle", out_valid, 1);
    drain();

    // R8 named patterns on 0x68
    send(X68, ONES, 1'b0, 5'b01010, 1'b0, {1'b0, 64'h7},  "R8 set-before-first");
    send(X68, ONES, 1'b0, 5'b01001, 1'b0, {1'b0, 64'h8},  "R8 isolate-first");
    send(X68, ONES, 1'b0, 5'b10000, 1'b0, {1'b0, 64'hF},  "R8 set-including-first");
    send(X68, ONES, 1'b0, 5'b10011, 1'b0, {1'b0, 64'hF},  "R8 alt set-including-first");
    // R1 mask source
    send(X68, 64'h0, 1'b1, 5'b01001, 1'b0, {1'b0, 64'h8}, "R1 zero flag gives all ones");
    send(X68, 64'h0, 1'b0, 5'b01001, 1'b0, {1'b0, 64'h0}, "R1 empty mask operand");
    send(X68, 64'h60, 1'b0, 5'b01001, 1'b0, {1'b0, 64'h20}, "R1 source masked first");
    // R2 first term
    send(X68, ONES, 1'b0, 5'b00001, 1'b0, {1'b0, 64'hFFFF_FFFF_FFFF_FFF8}, "R2 true term");
    send(X68, ONES, 1'b0, 5'b00000, 1'b0, {1'b0, 64'hFFFF_FFFF_FFFF_FF9F}, "R2 complement term");
    // R3 second term
    send(X68, ONES, 1'b0, 5'b00101, 1'b0, {1'b0, 64'h69}, "R3 increment");
    send(X68, ONES, 1'b0, 5'b00111, 1'b0, {1'b0, 64'hFFFF_FFFF_FFFF_FFFE}, "R3 not-increment");
    send(X68, ONES, 1'b0, 5'b01011, 1'b0, {1'b0, 64'h60}, "R3 decrement");
    // R4 combiners
    send(X68, ONES, 1'b0, 5'b10101, 1'b0, {1'b0, 64'h1}, "R4 xor");
    send(X68, ONES, 1'b0, 5'b01101, 1'b0, {1'b0, 64'h68}, "R4 and");
    // R9 wrap
    send(64'h0, ONES, 1'b0, 5'b10011, 1'b0, {1'b0, ONES}, "R9 zero minus one");
    send(ONES, ONES, 1'b0, 5'b10101, 1'b0, {1'b0, ONES}, "R9 ones plus one");
    send(64'h0, 64'hFF, 1'b0, 5'b10011, 1'b0, {1'b0, 64'hFF}, "R9 wrap within mask");
    // R5 reserved
    send(ONES, 64'hF0, 1'b0, 5'b11001, 1'b1, {1'b1, 64'h0}, "R5 reserved with keep");
    // R6 / R7 outside bits
    send(64'hAB00, 64'hFF, 1'b0, 5'b01001, 1'b0, {1'b0, 64'h0}, "R6 outside cleared");
    send(64'hAB00, 64'hFF, 1'b0, 5'b01001, 1'b1, {1'b0, 64'hAB00}, "R7 outside kept");
    drain();

    // R11: back-pressure hold
    hold = 1'b1;
    send(X68, ONES, 1'b0, 5'b01010, 1'b0, {1'b0, 64'h7}, "R11 held result");
    repeat (3) @(negedge clk);
    #2;
    check(out_valid && !in_ready && out_result == 64'h7,
          "R11 stall holds", {out_valid, in_ready, out_result}, {1'b1, 1'b0, 64'h7});
    hold = 1'b0;
    drain();

    // full sweep with irregular ready
    stall_en = 1'b1;
    for (int s = 0; s < 32; s++)
      for (int k = 0; k < 2; k++)
        for (int z = 0; z < 2; z++)
          for (int o = 0; o < 4; o++)
            sendm(srcs[o], masks[o], z[0], s[4:0], k[0],
                  (s[4:3] == 2'b11) ? "R5 sweep" : (k != 0 ? "R7 sweep" : "R6 sweep"));
    drain();
    stall_en = 1'b0;
    drain();
    check(q.size() == 0, "R10 all outputs delivered", q.size(), 0);

    done = 1'b1;
    report();
  end
endmodule